// File: doc/BRIEF.md
# Codec Control-Port Serializer with Power-Up Loader

This block programs an audio codec through a write-only, three-wire, SPI-like control port. It drives the pins directly as timed line steps. Each command carries a 7-bit register address and a 9-bit value, packed into one 16-bit frame. Between any two line steps the block waits a programmable number of system clocks, `SETTLE_CYC`, which sets the settle time the codec needs (about 1 µs).

When reset is released the block first pulses the codec reset pin. It then writes a fixed power-up table of 30 register writes. Routing and power registers come first in that table so that the outputs do not pop. After the table is done, a host can issue single writes through a valid/ready handshake. Every register written, by the table or by the host, is also stored in a local shadow file. Software can read that file combinationally by index, with no read over the wire.

Top module: `cdc_cfg`

## Requirements
- R1: While `rst_ni` is low: `cs_no`=1, `sclk_o`=0, `sdo_o`=0, `codec_rst_no`=1, `req_ready_o`=0 and `init_done_o`=0.
- R2: After reset release, `codec_rst_no` goes low on the first clock edge and stays low for exactly 2×SETTLE_CYC cycles, with `cs_no` high throughout. The first frame's chip-select fall comes at least SETTLE_CYC cycles after `codec_rst_no` rises.
- R3: A frame is 16 bits, with the address in bits 15:9 and the value in bits 8:0, sent MSB first. There are exactly 16 rising `sclk_o` edges while `cs_no` is low. `sdo_o` changes only while `sclk_o` is low, so the codec samples on the rising edge.
- R4: After the last bit, `sclk_o` falls and `cs_no` rises in the same cycle. Exactly one more rising `sclk_o` edge follows while `cs_no` is high, before the next frame.
- R5: Any two changes on the output pins are at least SETTLE_CYC cycles apart. A change on several pins in the same cycle counts as one change.
- R6: The first 30 frames are the power-up table, in this order:
  - 1B=044, 1C=00B, 1D=009, 18=000, 16=122, 17=022
  - 00..07=000
  - 08=100
  - 09..10=0FF
  - 11=1FF
  - 12=000, 13=090, 14=000, 15=000, 19=000, 1A=000
- R7: `init_done_o` rises once the trailing clock edge of the last table frame has finished, and it then stays high. `req_ready_o` is never high before that.
- R8: A host write is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both high. It sends the frame {`req_addr_i`,`req_data_i`}. `req_ready_o` is low from the cycle after acceptance for exactly 51×SETTLE_CYC cycles.
- R9: `rd_data_o` returns the last value written to index `rd_idx_i`, combinationally. It is 0 if that index was never written. An accepted write is visible from the cycle after acceptance.
- R10: A write whose address is at or above SHADOW_DEPTH is still sent on the wire, but it changes no shadow entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host write request |
| req_ready_o | output | 1 | Block can accept a host write |
| req_addr_i | input | 7 | Host write register address |
| req_data_i | input | 9 | Host write register value |
| rd_idx_i | input | log2(SHADOW_DEPTH) | Shadow read index |
| rd_data_o | output | 9 | Shadow read value |
| init_done_o | output | 1 | Power-up table completed |
| cs_no | output | 1 | Codec chip select, active low |
| sclk_o | output | 1 | Codec control clock |
| sdo_o | output | 1 | Codec control data |
| codec_rst_no | output | 1 | Codec reset, active low |

## Verification
An off-by-one in the step counter or the settle timer shows up on the pins within one frame:
- a wrong number of rising clock edges per frame;
- a missing or doubled trailing edge;
- a gap between line changes that is shorter than the settle count;
- a ready window that is not exactly 51 settle intervals.

A wrong table index or a premature done flag corrupts the first frames after reset, and that is visible before any host traffic starts. A shadow write that is misdirected or aliased is caught in the cycle after acceptance, by reading the written index and the aliased low index back through the read port.

// File: rtl/cdc_cfg_pkg.sv
package cdc_cfg_pkg;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 9;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int TBL_LEN = 30;

  typedef logic [ADDR_W-1:0] reg_addr_t;
  typedef logic [DATA_W-1:0] reg_data_t;

  // packed: addr lands in frame bits 15:9
  typedef struct packed {
    reg_addr_t addr;
    reg_data_t data;
  } cmd_t;

  typedef enum logic [2:0] {SH_IDLE, SH_BITS, SH_CSUP, SH_TAIL, SH_FIN} shift_st_e;
  typedef enum logic [2:0] {PU_ENTER, PU_RSTLO, PU_CSHI, PU_REL, PU_TBL, PU_RUN} seq_st_e;

  function automatic cmd_t init_cmd(input int i);
    cmd_t c;
    c = '0;
    if (i < 6) begin
      case (i)
        0: c = '{addr: 7'h1b, data: 9'h044};
        1: c = '{addr: 7'h1c, data: 9'h00b};
        2: c = '{addr: 7'h1d, data: 9'h009};
        3: c = '{addr: 7'h18, data: 9'h000};
        4: c = '{addr: 7'h16, data: 9'h122};
        default: c = '{addr: 7'h17, data: 9'h022};
      endcase
    end else if (i < 14) begin
      c.addr = reg_addr_t'(i - 6);
      c.data = 9'h000;
    end else if (i == 14) begin
      c = '{addr: 7'h08, data: 9'h100};
    end else if (i < 23) begin
      c.addr = reg_addr_t'(i - 15 + 9);
      c.data = 9'h0ff;
    end else if (i == 23) begin
      c = '{addr: 7'h11, data: 9'h1ff};
    end else begin
      case (i)
        24: c = '{addr: 7'h12, data: 9'h000};
        25: c = '{addr: 7'h13, data: 9'h090};
        26: c = '{addr: 7'h14, data: 9'h000};
        27: c = '{addr: 7'h15, data: 9'h000};
        28: c = '{addr: 7'h19, data: 9'h000};
        default: c = '{addr: 7'h1a, data: 9'h000};
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/cdc_cfg_shift.sv
module cdc_cfg_shift
  import cdc_cfg_pkg::*;
#(
  parameter int SETTLE_CYC = 250
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  cmd_t       cmd_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       cs_no,
  output logic       sclk_o,
  output logic       sdo_o
);
  localparam int TW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int BW = $clog2(FRAME_W);
  localparam logic [TW-1:0] RELOAD = TW'(SETTLE_CYC - 1);

  shift_st_e          st_q;
  logic [TW-1:0]      tmr_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BW-1:0]      bit_q;
  logic [1:0]         sub_q;
  logic               tick;

  assign tick   = (tmr_q == '0);
  assign busy_o = (st_q != SH_IDLE);
  assign done_o = (st_q == SH_FIN) && tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SH_IDLE;
      tmr_q  <= '0;
      sh_q   <= '0;
      bit_q  <= '0;
      sub_q  <= '0;
      cs_no  <= 1'b1;
      sclk_o <= 1'b0;
      sdo_o  <= 1'b0;
    end else if (st_q == SH_IDLE) begin
      if (start_i) begin
        cs_no <= 1'b0;
        sh_q  <= cmd_i;
        bit_q <= '0;
        sub_q <= '0;
        tmr_q <= RELOAD;
        st_q  <= SH_BITS;
      end
    end else if (!tick) begin
      tmr_q <= tmr_q - 1'b1;
    end else begin
      tmr_q <= RELOAD;
      case (st_q)
        SH_BITS: begin
          case (sub_q)
            2'd0: begin
              sclk_o <= 1'b0;
              sub_q  <= 2'd1;
            end
            2'd1: begin
              sdo_o <= sh_q[FRAME_W-1];
              sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
              sub_q <= 2'd2;
            end
            default: begin
              sclk_o <= 1'b1;
              sub_q  <= 2'd0;
              if (bit_q == BW'(FRAME_W - 1)) st_q <= SH_CSUP;
              else bit_q <= bit_q + 1'b1;
            end
          endcase
        end
        SH_CSUP: begin
          sclk_o <= 1'b0;
          cs_no  <= 1'b1;
          st_q   <= SH_TAIL;
        end
        SH_TAIL: begin
          sclk_o <= 1'b1;
          st_q   <= SH_FIN;
        end
        default: st_q <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cdc_cfg_seq.sv
module cdc_cfg_seq
  import cdc_cfg_pkg::*;
#(
  parameter int SETTLE_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ser_busy_i,
  input  logic ser_done_i,
  output logic tbl_start_o,
  output cmd_t tbl_cmd_o,
  output logic init_done_o,
  output logic codec_rst_no
);
  localparam int TW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int IW = $clog2(TBL_LEN);
  localparam logic [TW-1:0] RELOAD = TW'(SETTLE_CYC - 1);

  seq_st_e       st_q;
  logic [TW-1:0] tmr_q;
  logic [IW-1:0] idx_q;
  logic          tick;

  assign tick        = (tmr_q == '0);
  assign tbl_start_o = (st_q == PU_TBL) && !ser_busy_i;
  assign tbl_cmd_o   = init_cmd(int'(idx_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= PU_ENTER;
      tmr_q        <= '0;
      idx_q        <= '0;
      init_done_o  <= 1'b0;
      codec_rst_no <= 1'b1;
    end else begin
      case (st_q)
        PU_ENTER: begin
          codec_rst_no <= 1'b0;
          tmr_q        <= RELOAD;
          st_q         <= PU_RSTLO;
        end
        PU_RSTLO, PU_CSHI, PU_REL: begin
          if (!tick) tmr_q <= tmr_q - 1'b1;
          else begin
            tmr_q <= RELOAD;
            // chip select is already held high by the idle serializer
            if (st_q == PU_RSTLO) st_q <= PU_CSHI;
            else if (st_q == PU_CSHI) begin
              codec_rst_no <= 1'b1;
              st_q         <= PU_REL;
            end else st_q <= PU_TBL;
          end
        end
        PU_TBL: begin
          if (ser_done_i) begin
            if (idx_q == IW'(TBL_LEN - 1)) begin
              st_q        <= PU_RUN;
              init_done_o <= 1'b1;
            end else idx_q <= idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cdc_cfg_shadow.sv
module cdc_cfg_shadow
  import cdc_cfg_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  cmd_t                     wcmd_i,
  input  logic [$clog2(DEPTH)-1:0] ridx_i,
  output reg_data_t                rdata_o
);
  reg_data_t mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[g] <= '0;
      else if (we_i && (wcmd_i.addr == reg_addr_t'(g))) mem_q[g] <= wcmd_i.data;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/cdc_cfg.sv
module cdc_cfg
  import cdc_cfg_pkg::*;
#(
  parameter int SETTLE_CYC   = 250,
  parameter int SHADOW_DEPTH = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  output logic                            req_ready_o,
  input  logic [6:0]                      req_addr_i,
  input  logic [8:0]                      req_data_i,
  input  logic [$clog2(SHADOW_DEPTH)-1:0] rd_idx_i,
  output logic [8:0]                      rd_data_o,
  output logic                            init_done_o,
  output logic                            cs_no,
  output logic                            sclk_o,
  output logic                            sdo_o,
  output logic                            codec_rst_no
);
  logic ser_busy, ser_done, tbl_start, host_acc, ser_start;
  cmd_t tbl_cmd, ser_cmd;

  assign req_ready_o = init_done_o && !ser_busy;
  assign host_acc    = req_valid_i && req_ready_o;
  assign ser_start   = tbl_start || host_acc;
  assign ser_cmd     = tbl_start ? tbl_cmd : '{addr: req_addr_i, data: req_data_i};

  cdc_cfg_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ser_busy_i   (ser_busy),
    .ser_done_i   (ser_done),
    .tbl_start_o  (tbl_start),
    .tbl_cmd_o    (tbl_cmd),
    .init_done_o  (init_done_o),
    .codec_rst_no (codec_rst_no)
  );

  cdc_cfg_shift #(.SETTLE_CYC(SETTLE_CYC)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ser_start),
    .cmd_i   (ser_cmd),
    .busy_o  (ser_busy),
    .done_o  (ser_done),
    .cs_no   (cs_no),
    .sclk_o  (sclk_o),
    .sdo_o   (sdo_o)
  );

  cdc_cfg_shadow #(.DEPTH(SHADOW_DEPTH)) u_shadow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ser_start),
    .wcmd_i  (ser_cmd),
    .ridx_i  (rd_idx_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: rtl/cdc_cfg_chk.sv
module cdc_cfg_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic init_done_o,
  input logic cs_no,
  input logic sclk_o,
  input logic sdo_o,
  input logic codec_rst_no
);
  // R4
  cs_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cs_no) && !$stable(sclk_o)) |-> (cs_no && !sclk_o));

  // R3
  data_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> !sclk_o);

  // R7
  ready_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> init_done_o);

  // R7
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  // R8
  busy_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);

  // R2
  reset_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !codec_rst_no |-> (cs_no && !init_done_o));
endmodule

bind cdc_cfg cdc_cfg_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .init_done_o  (init_done_o),
  .cs_no        (cs_no),
  .sclk_o       (sclk_o),
  .sdo_o        (sdo_o),
  .codec_rst_no (codec_rst_no)
);

// File: tb/cdc_cfg_bench.sv
`timescale 1ns/1ps
module cdc_cfg_bench;
  localparam int S     = 3;
  localparam int DEPTH = 32;
  localparam int NTBL  = 30;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid = 1'b0;
  logic       ready;
  logic [6:0] addr = '0;
  logic [8:0] data = '0;
  logic [4:0] rd_idx = '0;
  logic [8:0] rd_data;
  logic       init_done, cs, sclk, sdo, crst;

  always #2 clk = ~clk;

  cdc_cfg #(.SETTLE_CYC(S), .SHADOW_DEPTH(DEPTH)) u_cdc_cfg (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid), .req_ready_o(ready),
    .req_addr_i(addr), .req_data_i(data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .init_done_o(init_done), .cs_no(cs), .sclk_o(sclk), .sdo_o(sdo),
    .codec_rst_no(crst)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_tbl(input int i);
    logic [6:0] a; logic [8:0] d;
    a = 7'h00; d = 9'h000;
    if (i == 0) begin a = 7'h1b; d = 9'h044; end
    else if (i == 1) begin a = 7'h1c; d = 9'h00b; end
    else if (i == 2) begin a = 7'h1d; d = 9'h009; end
    else if (i == 3) a = 7'h18;
    else if (i == 4) begin a = 7'h16; d = 9'h122; end
    else if (i == 5) begin a = 7'h17; d = 9'h022; end
    else if (i <= 13) a = 7'(i - 6);
    else if (i == 14) begin a = 7'h08; d = 9'h100; end
    else if (i <= 22) begin a = 7'(i - 6); d = 9'h0ff; end
    else if (i == 23) begin a = 7'h11; d = 9'h1ff; end
    else if (i == 24) a = 7'h12;
    else if (i == 25) begin a = 7'h13; d = 9'h090; end
    else if (i == 26) a = 7'h14;
    else if (i == 27) a = 7'h15;
    else if (i == 28) a = 7'h19;
    else a = 7'h1a;
    return {a, d};
  endfunction

  // pin monitor
  int          cyc = 0;
  logic        p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0, p_rst = 1'b1;
  int          last_chg = -1;
  logic [15:0] acc = '0;
  int          bitcnt = 0, tailcnt = 0, cap_n = 0;
  logic [15:0] cap [0:127];

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (cs !== p_cs || sclk !== p_sclk || sdo !== p_sdo || crst !== p_rst) begin
        if (last_chg >= 0 && (cyc - last_chg) < S) chk(0, "R5 settle gap", cyc - last_chg, S);
        last_chg = cyc;
      end
      if (sclk && !p_sclk) begin
        if (!cs) begin acc = {acc[14:0], sdo}; bitcnt++; end
        else tailcnt++;
      end
      if (cs && !p_cs) begin
        chk(!sclk, "R4 sclk low at cs release", int'(sclk), 0);
        chk(bitcnt == 16, "R3 rising edges per frame", bitcnt, 16);
        if (cap_n < 128) cap[cap_n] = acc;
        cap_n++;
        bitcnt  = 0;
        tailcnt = 0;
      end
      if (!cs && p_cs && cap_n > 0) chk(tailcnt == 1, "R4 trailing edge count", tailcnt, 1);
    end
    p_cs = cs; p_sclk = sclk; p_sdo = sdo; p_rst = crst;
  end

  logic [8:0] sh_m [DEPTH];

  task automatic host_write(input logic [6:0] a, input logic [8:0] d);
    int w;
    int n0;
    n0 = cap_n;
    @(negedge clk);
    valid = 1'b1; addr = a; data = d;
    while (!ready) @(negedge clk);
    @(negedge clk);
    valid = 1'b0;
    chk(!ready, "R8 ready low after accept", int'(ready), 0);
    if (a < 7'(DEPTH)) sh_m[a[4:0]] = d;
    rd_idx = a[4:0];
    #0.5;
    chk(rd_data == sh_m[a[4:0]], (a < 7'(DEPTH)) ? "R9 shadow write" : "R10 high address ignored",
        int'(rd_data), int'(sh_m[a[4:0]]));
    w = 0;
    while (!ready && w < 1000) begin w++; @(negedge clk); end
    chk(w == 51 * S, "R8 busy window", w, 51 * S);
    chk(cap_n == n0 + 1, "R8 one frame per write", cap_n, n0 + 1);
    chk(cap[cap_n - 1] == {a, d}, "R3 host frame bits", int'(cap[cap_n - 1]), int'({a, d}));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    bit bad;
    int unsigned seed;
    seed = $urandom(32'h0c0dec0d);
    for (int i = 0; i < DEPTH; i++) sh_m[i] = '0;

    repeat (5) @(negedge clk);
    // R1
    chk(cs == 1'b1, "R1 cs reset", int'(cs), 1);
    chk(sclk == 1'b0, "R1 sclk reset", int'(sclk), 0);
    chk(sdo == 1'b0, "R1 sdo reset", int'(sdo), 0);
    chk(crst == 1'b1, "R1 codec reset idle", int'(crst), 1);
    chk(ready == 1'b0 && init_done == 1'b0, "R1 ready/done reset", int'({ready, init_done}), 0);
    rst_ni = 1'b1;

    // R2
    n = 0;
    while (crst && n < 20) begin @(negedge clk); n++; end
    chk(n == 1, "R2 reset pulse start", n, 1);
    n = 0; bad = 0;
    while (!crst && n < 1000) begin
      if (!cs) bad = 1;
      @(negedge clk); n++;
    end
    chk(n == 2 * S, "R2 reset pulse width", n, 2 * S);
    chk(!bad, "R2 cs high during reset", int'(bad), 0);
    n = 0;
    while (cs && n < 1000) begin @(negedge clk); n++; end
    chk(n >= S, "R2 gap before first frame", n, S);

    // R7
    bad = 0;
    while (!init_done) begin
      if (ready) bad = 1;
      @(negedge clk);
    end
    chk(!bad, "R7 no ready before done", int'(bad), 0);
    chk(tailcnt == 1 && cs, "R7 done after last trailing edge", tailcnt, 1);
    chk(ready, "R7 ready after done", int'(ready), 1);

    // R6
    chk(cap_n == NTBL, "R6 table length", cap_n, NTBL);
    for (int i = 0; i < NTBL; i++) begin
      chk(cap[i] == exp_tbl(i), "R6 table entry", int'(cap[i]), int'(exp_tbl(i)));
      sh_m[exp_tbl(i)[13:9]] = exp_tbl(i)[8:0];
    end

    // R9
    for (int i = 0; i < DEPTH; i++) begin
      rd_idx = 5'(i);
      #0.5;
      chk(rd_data == sh_m[i], "R9 shadow after table", int'(rd_data), int'(sh_m[i]));
    end

    // directed corners: top index, alias of index 0, max address
    host_write(7'h1f, 9'h1ff);
    host_write(7'h20, 9'h155);
    rd_idx = 5'h00; #0.5;
    chk(rd_data == 9'h000, "R10 alias index untouched", int'(rd_data), 0);
    host_write(7'h7f, 9'h0aa);
    host_write(7'h00, 9'h1a5);

    for (int k = 0; k < 30; k++) begin
      logic [6:0] a;
      logic [8:0] d;
      logic [4:0] p;
      a = 7'($urandom);
      if (k % 2 == 0) a = {2'b00, a[4:0]};
      d = 9'($urandom);
      host_write(a, d);
      p = 5'($urandom);
      rd_idx = p; #0.5;
      chk(rd_data == sh_m[p], "R9 shadow random read", int'(rd_data), int'(sh_m[p]));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule